// File: doc/BRIEF.md
# Width-Matching Port Adapter

The adapter sits between a storage core with 18-bit words and two external buses, one for writing and one for reading. Each bus can run 18 bits wide or 9 bits wide, chosen separately for the write side and the read side. The byte order used when a narrow bus is packed into or split out of a wide word is also chosen. All three choices are captured while master reset is held and stay fixed until the next master reset.

A narrow write port collects two 9-bit transfers and hands them to the core as one 18-bit word. A narrow read port hands out one core word as two 9-bit transfers, and takes the word from the core only after the second of them. A wide port passes words through in the same cycle. Every port uses a valid/ready handshake. A partial reset drops any half-built or half-read word and keeps the captured configuration.

Top module: `width_match_adapter`

## Requirements
- R1: While master reset is high, cfgWrNarrow low selects an 18-bit write port and cfgWrNarrow high selects a 9-bit write port.
- R2: While master reset is high, cfgRdNarrow low selects an 18-bit read port and cfgRdNarrow high selects a 9-bit read port.
- R3: cfgLittle low (big-endian) puts the first narrow transfer in core bits 17:9 and the second in bits 8:0. cfgLittle high (little-endian) puts the first in bits 8:0 and the second in bits 17:9. The same placement applies to packing on the write side and to splitting on the read side.
- R4: On a narrow port only bits 8:0 carry data. Write-data bits 17:9 have no effect on the core word, and read-data bits 17:9 are driven to zero.
- R5: The three configuration inputs are sampled only while master reset is high. Changing them afterwards does not change the widths or the byte order.
- R6: On a narrow read port each core word produces exactly two read transfers, and coreRdReady is asserted only for the second of them.
- R7: On a narrow write port the first half-word is accepted into a staging register without a core write. Exactly one core write, carrying both halves, takes place when the second half is accepted.
- R8: On a wide port, data, valid and ready pass between the external bus and the core in the same cycle with no staging.
- R9: A partial reset clears the staged half-word and the read-half position and keeps the captured widths and byte order. A core word that was half read is then read again from its first half.
- R10: After master reset no half-word is staged: a narrow write port is ready, no core write is pending, and no read is offered while the core is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstMaster | input | 1 | Synchronous master reset, active high; captures the configuration |
| rstPartial | input | 1 | Synchronous partial reset, active high; keeps the configuration |
| cfgWrNarrow | input | 1 | Write width select, sampled during master reset (1 = 9 bits) |
| cfgRdNarrow | input | 1 | Read width select, sampled during master reset (1 = 9 bits) |
| cfgLittle | input | 1 | Byte order select, sampled during master reset (1 = little-endian) |
| wrValid | input | 1 | Write bus valid |
| wrReady | output | 1 | Write bus ready |
| wrData | input | 18 | Write bus data |
| coreWrValid | output | 1 | Word valid toward the core |
| coreWrReady | input | 1 | Core can take a word |
| coreWrData | output | 18 | Word toward the core |
| coreRdValid | input | 1 | Core has a word to read |
| coreRdReady | output | 1 | Adapter takes the core word |
| coreRdData | input | 18 | Word from the core |
| rdValid | output | 1 | Read bus valid |
| rdReady | input | 1 | Read bus ready |
| rdData | output | 18 | Read bus data |

## Verification
The assertions assume that the core holds coreRdData steady while coreRdValid is high and the word has not been taken. They also assume that no transfer is attempted while either reset is high. The bench keeps to this. Its core model changes the head word only after a completed pop. All stimulus is applied away from the reset pulses. The configuration inputs are flipped right after every master reset, so that any dependence on their current value shows up as a data error.

// File: rtl/wadapt_pkg.sv
package wadapt_pkg;

  // Strobes and mode bits passed from control to datapath
  typedef struct packed {
    logic wrNarrow;   // write port is half width
    logic rdNarrow;   // read port is half width
    logic little;     // first half sits in the low lane
    logic wrHeld;     // a first half-word is staged
    logic rdSecond;   // next read delivers the second half
    logic stageLoad;  // capture the incoming half-word now
  } adaptStrobes_t;

endpackage

// File: rtl/wadapt_ctrl.sv
module wadapt_ctrl
  import wadapt_pkg::*;
(
  input  logic          clk,
  input  logic          rstMaster,
  input  logic          rstPartial,
  input  logic          cfgWrNarrow,
  input  logic          cfgRdNarrow,
  input  logic          cfgLittle,
  input  logic          wrValid,
  output logic          wrReady,
  output logic          coreWrValid,
  input  logic          coreWrReady,
  input  logic          coreRdValid,
  output logic          coreRdReady,
  output logic          rdValid,
  input  logic          rdReady,
  output adaptStrobes_t strobes
);

  logic wrNarrowQ, rdNarrowQ, littleQ;
  logic wrHeldQ, rdSecondQ;
  logic inReset;
  logic wrFire, rdFire;

  assign inReset = rstMaster | rstPartial;

  // configuration capture, only while master reset is held
  always_ff @(posedge clk) begin
    if (rstMaster) begin
      wrNarrowQ <= cfgWrNarrow;
      rdNarrowQ <= cfgRdNarrow;
      littleQ   <= cfgLittle;
    end
  end

  // handshake outputs, all blocked while any reset is active
  always_comb begin
    if (inReset) begin
      wrReady     = 1'b0;
      coreWrValid = 1'b0;
      coreRdReady = 1'b0;
      rdValid     = 1'b0;
    end else begin
      if (wrNarrowQ) begin
        wrReady     = wrHeldQ ? coreWrReady : 1'b1;
        coreWrValid = wrHeldQ & wrValid;
      end else begin
        wrReady     = coreWrReady;
        coreWrValid = wrValid;
      end
      rdValid     = coreRdValid;
      coreRdReady = rdNarrowQ ? (rdSecondQ & rdReady) : rdReady;
    end
  end

  assign wrFire = wrValid & wrReady;
  assign rdFire = rdValid & rdReady;

  // half-word phase tracking
  always_ff @(posedge clk) begin
    if (inReset) begin
      wrHeldQ   <= 1'b0;
      rdSecondQ <= 1'b0;
    end else begin
      if (wrNarrowQ && wrFire) wrHeldQ <= ~wrHeldQ;
      if (rdNarrowQ && rdFire) rdSecondQ <= ~rdSecondQ;
    end
  end

  always_comb begin
    strobes.wrNarrow  = wrNarrowQ;
    strobes.rdNarrow  = rdNarrowQ;
    strobes.little    = littleQ;
    strobes.wrHeld    = wrHeldQ;
    strobes.rdSecond  = rdSecondQ;
    strobes.stageLoad = wrNarrowQ & ~wrHeldQ & wrFire;
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rstMaster)
    !$past(rstMaster) |-> ($stable(wrNarrowQ) && $stable(rdNarrowQ) && $stable(littleQ))); // R5

  AST_CORE_WR_AFTER_SECOND: assert property (@(posedge clk) disable iff (rstMaster)
    (wrNarrowQ && coreWrValid) |-> wrHeldQ); // R7

  AST_CORE_POP_ON_SECOND: assert property (@(posedge clk) disable iff (rstMaster)
    (rdNarrowQ && coreRdValid && coreRdReady) |-> (rdSecondQ && rdFire)); // R6

  AST_PARTIAL_CLEARS: assert property (@(posedge clk) disable iff (rstMaster)
    $past(rstPartial) |-> (!wrHeldQ && !rdSecondQ)); // R9

endmodule

// File: rtl/wadapt_datapath.sv
module wadapt_datapath
  import wadapt_pkg::*;
#(
  parameter int HALF_W = 9,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstMaster,
  input  logic              rstPartial,
  input  adaptStrobes_t     strobes,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] coreWrData,
  input  logic [WORD_W-1:0] coreRdData,
  output logic [WORD_W-1:0] rdData
);

  logic [HALF_W-1:0] stageQ;
  logic [HALF_W-1:0] rdHalf;
  logic [HALF_W-1:0] lanes [2];
  logic              pickLow;

  // staging register for the first narrow write
  always_ff @(posedge clk) begin
    if (rstMaster || rstPartial) stageQ <= '0;
    else if (strobes.stageLoad)  stageQ <= wrData[HALF_W-1:0];
  end

  // packing: first half goes high for big-endian, low for little-endian
  always_comb begin
    if (!strobes.wrNarrow)
      coreWrData = wrData;
    else if (strobes.little)
      coreWrData = {wrData[HALF_W-1:0], stageQ};
    else
      coreWrData = {stageQ, wrData[HALF_W-1:0]};
  end

  // split core word into lanes
  for (genvar g = 0; g < 2; g++) begin : gLane
    assign lanes[g] = coreRdData[g*HALF_W +: HALF_W];
  end

  assign pickLow = strobes.rdSecond ^ strobes.little;
  assign rdHalf  = pickLow ? lanes[0] : lanes[1];
  assign rdData  = strobes.rdNarrow ? {{HALF_W{1'b0}}, rdHalf} : coreRdData;

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rstMaster)
    strobes.rdNarrow |-> (rdData[WORD_W-1:HALF_W] == '0)); // R4

endmodule

// File: rtl/width_match_adapter.sv
module width_match_adapter
  import wadapt_pkg::*;
#(
  parameter int HALF_W = 9,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstMaster,
  input  logic              rstPartial,
  input  logic              cfgWrNarrow,
  input  logic              cfgRdNarrow,
  input  logic              cfgLittle,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [WORD_W-1:0] wrData,
  output logic              coreWrValid,
  input  logic              coreWrReady,
  output logic [WORD_W-1:0] coreWrData,
  input  logic              coreRdValid,
  output logic              coreRdReady,
  input  logic [WORD_W-1:0] coreRdData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic [WORD_W-1:0] rdData
);

  adaptStrobes_t strobes;

  wadapt_ctrl uCtrl (
    .clk         (clk),
    .rstMaster   (rstMaster),
    .rstPartial  (rstPartial),
    .cfgWrNarrow (cfgWrNarrow),
    .cfgRdNarrow (cfgRdNarrow),
    .cfgLittle   (cfgLittle),
    .wrValid     (wrValid),
    .wrReady     (wrReady),
    .coreWrValid (coreWrValid),
    .coreWrReady (coreWrReady),
    .coreRdValid (coreRdValid),
    .coreRdReady (coreRdReady),
    .rdValid     (rdValid),
    .rdReady     (rdReady),
    .strobes     (strobes)
  );

  wadapt_datapath #(.HALF_W(HALF_W)) uData (
    .clk        (clk),
    .rstMaster  (rstMaster),
    .rstPartial (rstPartial),
    .strobes    (strobes),
    .wrData     (wrData),
    .coreWrData (coreWrData),
    .coreRdData (coreRdData),
    .rdData     (rdData)
  );

endmodule

// File: tb/tb_width_match_adapter.sv
module tb_width_match_adapter;

  logic        clk = 1'b0;
  logic        rstMaster = 1'b1;
  logic        rstPartial = 1'b0;
  logic        cfgWrNarrow = 1'b1, cfgRdNarrow = 1'b1, cfgLittle = 1'b0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [17:0] wrData = '0;
  logic        coreWrValid;
  logic        coreWrReady = 1'b1;
  logic [17:0] coreWrData;
  logic        coreRdValid = 1'b0;
  logic        coreRdReady;
  logic [17:0] coreRdData = '0;
  logic        rdValid;
  logic        rdReady = 1'b0;
  logic [17:0] rdData;

  int testsRun = 0, testsFailed = 0;
  logic [17:0] expWrQ[$], expRdQ[$], coreSrcQ[$];
  bit curWrN, curRdN, curLittle;
  bit wrStall = 0, rdToggle = 0, corePop = 0;
  bit finished = 0;
  int unsigned cyc = 0;

  always #4 clk = ~clk;

  width_match_adapter dut (
    .clk(clk), .rstMaster(rstMaster), .rstPartial(rstPartial),
    .cfgWrNarrow(cfgWrNarrow), .cfgRdNarrow(cfgRdNarrow), .cfgLittle(cfgLittle),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .coreWrValid(coreWrValid), .coreWrReady(coreWrReady), .coreWrData(coreWrData),
    .coreRdValid(coreRdValid), .coreRdReady(coreRdReady), .coreRdData(coreRdData),
    .rdValid(rdValid), .rdReady(rdReady), .rdData(rdData)
  );

  task automatic checkEq(input string tag, input logic [17:0] act, input logic [17:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // core model and ready generation, applied just after each rising edge
  always @(posedge clk) begin
    #2;
    cyc++;
    if (corePop && coreSrcQ.size() > 0) void'(coreSrcQ.pop_front());
    corePop = 0;
    coreRdValid = (coreSrcQ.size() > 0);
    coreRdData  = (coreSrcQ.size() > 0) ? coreSrcQ[0] : 18'h0;
    coreWrReady = wrStall ? cyc[0] : 1'b1;
    rdReady     = (expRdQ.size() > 0) && (!rdToggle || cyc[1]);
  end

  // monitor: sampled at the falling edge, transfers complete on the next rising edge
  always @(negedge clk) begin
    if (!rstMaster && !rstPartial) begin
      if (coreWrValid && coreWrReady) begin
        if (expWrQ.size() == 0) checkEq("R7 unexpected core write", coreWrData, 18'h3ffff ^ coreWrData);
        else checkEq("R1 R3 R4 R7 R8 core word", coreWrData, expWrQ.pop_front());
      end
      if (rdValid && rdReady) begin
        if (expRdQ.size() == 0) checkEq("R6 unexpected read", rdData, 18'h3ffff ^ rdData);
        else checkEq("R2 R3 R4 R6 R8 read data", rdData, expRdQ.pop_front());
      end
      corePop = coreRdValid && coreRdReady;
    end
  end

  task automatic masterReset(input bit wN, input bit rN, input bit lit);
    @(posedge clk); #2;
    cfgWrNarrow = wN; cfgRdNarrow = rN; cfgLittle = lit;
    rstMaster = 1'b1;
    expWrQ.delete(); expRdQ.delete(); coreSrcQ.delete();
    repeat (3) @(posedge clk);
    #2;
    rstMaster = 1'b0;
    // R5: flip the selects once reset is over
    cfgWrNarrow = ~wN; cfgRdNarrow = ~rN; cfgLittle = ~lit;
    curWrN = wN; curRdN = rN; curLittle = lit;
  endtask

  task automatic partialReset();
    @(posedge clk); #2;
    rstPartial = 1'b1;
    @(posedge clk); #2;
    rstPartial = 1'b0;
  endtask

  task automatic putWr(input logic [17:0] d);
    @(posedge clk); #2;
    wrValid = 1'b1; wrData = d;
    do @(negedge clk); while (!wrReady);
    @(posedge clk); #2;
    wrValid = 1'b0;
  endtask

  function automatic logic [17:0] packW(input logic [17:0] a, input logic [17:0] b);
    return curLittle ? {b[8:0], a[8:0]} : {a[8:0], b[8:0]};
  endfunction

  task automatic sendPair(input logic [17:0] a, input logic [17:0] b);
    expWrQ.push_back(packW(a, b));
    putWr(a);
    putWr(b);
  endtask

  task automatic sendWide(input logic [17:0] w);
    expWrQ.push_back(w);
    putWr(w);
  endtask

  task automatic loadCore(input logic [17:0] w);
    if (curRdN) begin
      expRdQ.push_back({9'h0, curLittle ? w[8:0] : w[17:9]});
      expRdQ.push_back({9'h0, curLittle ? w[17:9] : w[8:0]});
    end else begin
      expRdQ.push_back(w);
    end
    coreSrcQ.push_back(w);
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while ((expWrQ.size() > 0 || expRdQ.size() > 0) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    checkEq(tag, 18'(expWrQ.size() + expRdQ.size()), 18'h0);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // R10: reset state, both narrow, big-endian
    masterReset(1, 1, 0);
    @(negedge clk);
    checkEq("R10 wrReady after reset", 18'(wrReady), 18'h1);
    checkEq("R10 coreWrValid after reset", 18'(coreWrValid), 18'h0);
    checkEq("R10 rdValid after reset", 18'(rdValid), 18'h0);

    // R1 R3 R4 R7: narrow write big-endian, junk on upper bits
    sendPair(18'h3fe01, 18'h2aa55);
    sendPair(18'h00123, 18'h3ff0f);
    sendPair(18'h1ffff, 18'h00000);
    drain("R7 narrow big writes drained");

    // R2 R3 R4 R6: narrow read big-endian with read stalls
    rdToggle = 1;
    loadCore(18'h2b3c4);
    loadCore(18'h1a5f0);
    loadCore(18'h3ffff);
    drain("R6 narrow big reads drained");
    checkEq("R6 core words consumed", 18'(coreSrcQ.size()), 18'h0);
    rdToggle = 0;

    // R3 R5: little-endian, selects flipped after reset
    masterReset(1, 1, 1);
    sendPair(18'h20011, 18'h1c022);
    sendPair(18'h001ab, 18'h00154);
    loadCore(18'h12345);
    loadCore(18'h3c00f);
    drain("R3 little narrow drained");

    // R8: both wide, with core write back-pressure
    masterReset(0, 0, 0);
    wrStall = 1;
    sendWide(18'h3a5c3);
    sendWide(18'h00001);
    sendWide(18'h2ffff);
    loadCore(18'h1b2c3);
    loadCore(18'h3fe00);
    drain("R8 wide passthrough drained");
    @(posedge clk); #2;
    wrValid = 1'b1; wrData = 18'h15a5a;
    do @(negedge clk); while (coreWrReady);
    checkEq("R8 wrReady follows core ready", 18'(wrReady), 18'h0);
    checkEq("R8 data passes through", coreWrData, 18'h15a5a);
    @(posedge clk); #2; wrValid = 1'b0;
    wrStall = 0;

    // R1 R2: wide write with narrow read, little-endian
    masterReset(0, 1, 1);
    sendWide(18'h2468a);
    loadCore(18'h3579b);
    drain("R1 R2 wide write narrow read drained");

    // R1 R2: narrow write with wide read, big-endian
    masterReset(1, 0, 0);
    sendPair(18'h00abc, 18'h00def);
    loadCore(18'h13579);
    drain("R1 R2 narrow write wide read drained");

    // R9: partial reset drops a staged half and keeps the configuration
    masterReset(1, 1, 0);
    putWr(18'h00111);
    partialReset();
    sendPair(18'h00122, 18'h00133);
    drain("R9 staged half discarded");

    // R9: partial reset mid-read restarts the word from its first half
    coreSrcQ.push_back(18'h2d0b4);
    expRdQ.push_back({9'h0, 9'h168});
    drain("R9 first half read");
    partialReset();
    expRdQ.push_back({9'h0, 9'h168});
    expRdQ.push_back({9'h0, 9'h0b4});
    drain("R9 word read again after partial reset");
    checkEq("R9 core word consumed once", 18'(coreSrcQ.size()), 18'h0);

    // R10: master reset clears a staged half
    putWr(18'h00077);
    masterReset(1, 1, 0);
    @(negedge clk);
    checkEq("R10 wrReady after mid-word reset", 18'(wrReady), 18'h1);
    sendPair(18'h00088, 18'h00099);
    drain("R10 clean pair after master reset");

    repeat (4) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule